// File: doc/BRIEF.md
# Paged CSR Window Decoder

The block sits between a 32-bit register-access bus and a register space that is larger than the bus can address directly. The bus sees a 4 KiB window. Offsets in the lower part of that window reach the register space unchanged. The top 1 KiB of the window is a sliding aperture: a 6-bit page index, kept in a control register that also lives in the register space, picks which 1 KiB slice of a 64 KiB internal space the aperture shows.

Each request carries an offset, a byte count and, for a write, right-justified data. The block checks the size and alignment and forms the internal address. It applies byte-lane enables and answers one cycle later with read data or an error flag. The register space behind the decoder is a plain behavioural word array. The control register is a real flop register decoded at its internal address.

Top module: `paged_csr_decoder`

## Requirements
- R1: After reset the control register reads as zero, so the page index is 0.
- R2: A bus offset below 0xC00 addresses internal byte address equal to the offset.
- R3: A bus offset of 0xC00 or above addresses internal byte address {page, offset[9:0]} (16 bits), where page is the current page index. With page 0 this aliases internal 0x000–0x3FF.
- R4: The page index is control register bits [18:13]. The control register sits at internal address 0x808, and a 4-byte read there returns all 32 bits.
- R5: A write to the control register changes only the byte lanes it enables. Other bits keep their value, and a new page index takes effect from the next request.
- R6: `req_size` holds the byte count. Legal sizes are 1, 2 and 4, with `req_offset[1:0]` picking the lowest lane. A legal write updates only the enabled lanes, taking data from the low bits of `req_wdata`.
- R7: A legal read returns the selected lanes shifted down to bit 0, with all bits above the access width zero. A write returns zero data.
- R8: A 2-byte access at an odd offset, or a 4-byte access with a nonzero `req_offset[1:0]`, sets `rsp_err`, returns zero data and changes nothing.
- R9: A size of 0, 3, 5, 6 or 7 sets `rsp_err`, returns zero data and changes nothing.
- R10: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high.
- R11: The control register is reached through the aperture too: with page 2, bus offset 0xC08 accesses it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 12 | Byte offset in the bus window |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data, right-justified |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Bad-register error |
| rsp_rdata | output | 32 | Read data, right-justified |

## Verification
The bench builds the block with a 14-bit store address. That gives 16 Ki words, which is the whole 64 KiB internal space with no aliasing in the store. Every one of the 64 pages can therefore be written and read back through the aperture and compared against an arithmetic model. The same setting makes page 0 to 2 overlap the direct region and page 2 reach the control register, so those aliases are checked against writes made through the direct path.

// File: rtl/csrpg_pkg.sv
package csrpg_pkg;

    localparam int BUS_AW     = 12;
    localparam int LOW_W      = 10;
    localparam int PAGE_W     = 6;
    localparam int PAGE_LSB   = 13;
    localparam int INT_AW     = PAGE_W + LOW_W;
    localparam int WORD_AW    = INT_AW - 2;
    localparam int DATA_W     = 32;
    localparam int LANES      = DATA_W / 8;

    localparam logic [BUS_AW-1:0] APERTURE_BASE = 12'hC00;
    localparam logic [INT_AW-1:0] CTRL_ADDR     = 16'h0808;

    typedef struct packed {
        logic              legal;
        logic              is_ctrl;
        logic [1:0]        lane;
        logic [LANES-1:0]  be;
        logic [INT_AW-1:0] addr;
    } access_t;

    function automatic logic size_ok(input logic [2:0] size, input logic [1:0] lane);
        case (size)
            3'd1:    return 1'b1;
            3'd2:    return ~lane[0];
            3'd4:    return lane == 2'd0;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [LANES-1:0] lane_enables(input logic [2:0] size,
                                                     input logic [1:0] lane);
        case (size)
            3'd1:    return 4'b0001 << lane;
            3'd2:    return 4'b0011 << lane;
            3'd4:    return 4'b1111;
            default: return 4'b0000;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] justify_read(input logic [DATA_W-1:0] word,
                                                      input logic [1:0] lane,
                                                      input logic [2:0] size);
        logic [DATA_W-1:0] s;
        s = word >> {lane, 3'b000};
        case (size)
            3'd1:    return {24'b0, s[7:0]};
            3'd2:    return {16'b0, s[15:0]};
            default: return s;
        endcase
    endfunction

endpackage

// File: rtl/csrpg_addr_map.sv
module csrpg_addr_map
    import csrpg_pkg::*;
(
    input  logic [BUS_AW-1:0] offset,
    input  logic [2:0]        size,
    input  logic [PAGE_W-1:0] page,
    output access_t           acc
);
    logic in_aperture;

    always_comb begin
        in_aperture = offset >= APERTURE_BASE;
        acc.lane    = offset[1:0];
        acc.legal   = size_ok(size, offset[1:0]);
        acc.be      = acc.legal ? lane_enables(size, offset[1:0]) : '0;
        if (in_aperture)
            acc.addr = {page, offset[LOW_W-1:0]};
        else
            acc.addr = INT_AW'(offset);
        acc.is_ctrl = acc.addr[INT_AW-1:2] == CTRL_ADDR[INT_AW-1:2];
    end

    // R6
    always_comb begin
        if (acc.legal)
            lane_count_chk: assert ($countones(acc.be) == int'(size));
    end

endmodule

// File: rtl/csrpg_page_ctrl.sv
module csrpg_page_ctrl
    import csrpg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [LANES-1:0]  be,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [PAGE_W-1:0] page
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            for (int b = 0; b < LANES; b++)
                if (be[b]) ctrl_q[b*8 +: 8] <= wdata[b*8 +: 8];
        end
    end

    assign page = ctrl_q[PAGE_LSB +: PAGE_W];

    // R1
    reset_page_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (page == '0));

endmodule

// File: rtl/csrpg_store.sv
module csrpg_store
    import csrpg_pkg::*;
#(
    parameter int STORE_AW = 10
) (
    input  logic               clk,
    input  logic               wr_en,
    input  logic [LANES-1:0]   be,
    input  logic [WORD_AW-1:0] word_addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata
);
    localparam int DEPTH = 1 << STORE_AW;
    localparam int IDX_W = (STORE_AW < WORD_AW) ? STORE_AW : WORD_AW;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [IDX_W-1:0]  idx;

    generate
        if (IDX_W < WORD_AW) begin : g_fold
            logic unused_addr_hi;
            assign idx            = word_addr[IDX_W-1:0];
            assign unused_addr_hi = ^word_addr[WORD_AW-1:IDX_W];
        end else begin : g_full
            assign idx = word_addr;
        end
    endgenerate

    generate
        for (genvar b = 0; b < LANES; b++) begin : g_lane
            always_ff @(posedge clk) begin
                if (wr_en && be[b])
                    mem[idx][b*8 +: 8] <= wdata[b*8 +: 8];
            end
        end
    endgenerate

    assign rdata = mem[idx];

endmodule

// File: rtl/paged_csr_decoder.sv
module paged_csr_decoder
    import csrpg_pkg::*;
#(
    parameter int STORE_AW = 10
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [11:0] req_offset,
    input  logic [2:0]  req_size,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic        rsp_err,
    output logic [31:0] rsp_rdata
);
    access_t           acc;
    logic [PAGE_W-1:0] page;
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] store_rdata;
    logic [DATA_W-1:0] wdata_lanes;
    logic [DATA_W-1:0] word_rd;
    logic              do_write;

    csrpg_addr_map i_map (
        .offset (req_offset),
        .size   (req_size),
        .page   (page),
        .acc    (acc)
    );

    assign wdata_lanes = req_wdata << {acc.lane, 3'b000};
    assign do_write    = req_valid && req_write && acc.legal;

    csrpg_page_ctrl i_ctrl (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (do_write && acc.is_ctrl),
        .be     (acc.be),
        .wdata  (wdata_lanes),
        .ctrl_q (ctrl_q),
        .page   (page)
    );

    csrpg_store #(.STORE_AW(STORE_AW)) i_store (
        .clk       (clk),
        .wr_en     (do_write && !acc.is_ctrl),
        .be        (acc.be),
        .word_addr (acc.addr[INT_AW-1:2]),
        .wdata     (wdata_lanes),
        .rdata     (store_rdata)
    );

    assign word_rd = acc.is_ctrl ? ctrl_q : store_rdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && !acc.legal;
            if (req_valid && acc.legal && !req_write)
                rsp_rdata <= justify_read(word_rd, acc.lane, req_size);
            else
                rsp_rdata <= '0;
        end
    end

    // R10
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R10
    idle_no_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R8
    err_zero_data_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (rsp_valid && rsp_rdata == '0));

    // R9
    err_keeps_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !acc.legal) |=> $stable(ctrl_q));

endmodule

// File: tb/test_paged_csr_decoder.sv
module test_paged_csr_decoder;

    localparam int SAW = 14;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_offset = '0;
    logic [2:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic        rsp_err;
    logic [31:0] rsp_rdata;

    int n_checks = 0;
    int n_fails  = 0;

    logic [31:0] mem [1 << SAW];
    logic [31:0] mctrl = '0;

    always #2 clk = ~clk;

    paged_csr_decoder #(.STORE_AW(SAW)) i_paged_csr_decoder (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_offset(req_offset), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata));

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    function automatic bit legal(input int off, input int size);
        return (size == 1) || (size == 2 && (off % 2) == 0) || (size == 4 && (off % 4) == 0);
    endfunction

    function automatic int eff(input int off);
        if (off >= 'hC00) return ((int'(mctrl >> 13) & 63) << 10) | (off & 'h3FF);
        return off;
    endfunction

    function automatic logic [31:0] mword(input int e);
        if ((e >> 2) == ('h808 >> 2)) return mctrl;
        return mem[e >> 2];
    endfunction

    function automatic logic [31:0] expect_rd(input int off, input int size);
        logic [31:0] s;
        s = mword(eff(off)) >> (8 * (off % 4));
        if (size == 1) return s & 32'hFF;
        if (size == 2) return s & 32'hFFFF;
        return s;
    endfunction

    task automatic model_wr(input int off, input int size, input logic [31:0] wd);
        int e;
        logic [31:0] w;
        if (!legal(off, size)) return;
        e = eff(off);
        w = mword(e);
        for (int b = 0; b < size; b++)
            w[((off % 4) + b) * 8 +: 8] = wd[b * 8 +: 8];
        if ((e >> 2) == ('h808 >> 2)) mctrl = w;
        else mem[e >> 2] = w;
    endtask

    task automatic access(input bit wr, input int off, input int size,
                          input logic [31:0] wd, output logic [31:0] rd, output bit er);
        @(negedge clk);
        req_valid  = 1'b1;
        req_write  = wr;
        req_offset = off[11:0];
        req_size   = size[2:0];
        req_wdata  = wd;
        @(negedge clk);
        req_valid = 1'b0;
        rd = rsp_rdata;
        er = rsp_err;
        chk(rsp_valid === 1'b1, "R10 rsp_valid after request", {31'b0, rsp_valid}, 32'h1);
    endtask

    task automatic wr(input int off, input int size, input logic [31:0] wd, input string tag);
        logic [31:0] rd;
        bit er;
        access(1'b1, off, size, wd, rd, er);
        chk(er == 1'b0 && rd == 32'h0, tag, rd, 32'h0);
        model_wr(off, size, wd);
    endtask

    task automatic rdchk(input int off, input int size, input string tag);
        logic [31:0] rd;
        logic [31:0] exp;
        bit er;
        exp = expect_rd(off, size);
        access(1'b0, off, size, 32'h0, rd, er);
        chk(er == 1'b0 && rd === exp, tag, rd, exp);
    endtask

    task automatic badchk(input int off, input int size, input string tag);
        logic [31:0] rd;
        bit er;
        access(1'b1, off, size, 32'hFFFF_FFFF, rd, er);
        chk(er == 1'b1 && rd == 32'h0, tag, {31'b0, er}, 32'h1);
        access(1'b0, off, size, 32'h0, rd, er);
        chk(er == 1'b1 && rd == 32'h0, tag, rd, 32'h0);
        rdchk(off & ~3, 4, tag);
    endtask

    initial begin
        #(4 * 150000);
        chk(1'b0, "watchdog expired", 32'h0, 32'h1);
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        bit er;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R10 idle after reset", {31'b0, rsp_valid}, 32'h0);

        // R1: control register is zero after reset
        rdchk('h808, 4, "R1 control reset");

        // R2: direct region sweep, every word except the control word
        for (int w = 0; w < 'h300; w++)
            if (w != ('h808 >> 2)) wr(w * 4, 4, 32'h5000_0000 ^ (w * 32'h0001_0203), "R2 direct write");
        for (int w = 0; w < 'h300; w++)
            if (w != ('h808 >> 2)) rdchk(w * 4, 4, "R2 direct read");
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R10 no response when idle", {31'b0, rsp_valid}, 32'h0);

        // R3: page 0 aperture aliases the bottom of the direct region
        for (int i = 0; i < 256; i++) rdchk('hC00 + i * 4, 4, "R3 page0 alias");

        // R3, R4: every page written and read through the aperture
        for (int p = 0; p < 64; p++) begin
            wr('h808, 4, (p << 13) | 32'h8000_1001, "R4 page write");
            rdchk('h808, 4, "R4 control read");
            for (int k = 0; k < 4; k++)
                wr('hC00 + k * 'h100 + 'h10 + (p % 4) * 4, 4, 32'hA000_0000 | (p << 8) | k, "R3 paged write");
            for (int k = 0; k < 4; k++)
                rdchk('hC00 + k * 'h100 + 'h10 + (p % 4) * 4, 4, "R3 paged read");
        end
        for (int p = 0; p < 64; p++) begin
            wr('h808, 4, p << 13, "R4 page revisit");
            for (int k = 0; k < 4; k++)
                rdchk('hC00 + k * 'h100 + 'h10 + (p % 4) * 4, 4, "R3 page isolation");
        end
        wr('h808, 4, 32'h0, "R4 page back to zero");
        for (int w = 0; w < 'h300; w += 7)
            if (w != ('h808 >> 2)) rdchk(w * 4, 4, "R2 direct after paging");

        // R6, R7: byte lanes
        wr('h100, 4, 32'h0, "R6 clear word");
        for (int l = 0; l < 4; l++) begin
            wr('h100 + l, 1, 32'hFFFF_FF00 | (8'h11 * (l + 1)), "R6 byte write");
            rdchk('h100, 4, "R6 byte lane merge");
        end
        for (int l = 0; l < 4; l++) rdchk('h100 + l, 1, "R7 byte read");
        for (int l = 0; l < 4; l += 2) begin
            wr('h104 + l, 2, 32'hDEAD_0000 | (16'h1234 + l), "R6 half write");
            rdchk('h104 + l, 2, "R7 half read");
        end
        rdchk('h104, 4, "R6 half merge");
        wr('hC00, 4, 32'h89AB_CDEF, "R6 paged word");
        for (int l = 0; l < 4; l++) rdchk('hC00 + l, 1, "R7 paged byte read");

        // R8: misaligned accesses
        badchk('h101, 2, "R8 odd half");
        badchk('h103, 2, "R8 odd half top");
        for (int l = 1; l < 4; l++) badchk('h104 + l, 4, "R8 unaligned word");
        badchk('hC02 + 1, 4, "R8 unaligned paged");

        // R9: illegal sizes
        badchk('h100, 0, "R9 size 0");
        badchk('h100, 3, "R9 size 3");
        for (int s = 5; s < 8; s++) badchk('h100, s, "R9 size 5..7");
        badchk('h808, 3, "R9 control untouched");
        rdchk('h808, 4, "R9 control after error");

        // R5: partial writes to the control register
        wr('h808, 4, 32'h1234_5678, "R5 control full");
        wr('h80A, 1, 32'h0000_0005, "R5 control byte");
        rdchk('h808, 4, "R5 other bits kept");
        wr('hC20, 4, 32'h0BAD_F00D, "R5 new page used");
        rdchk('hC20, 4, "R5 new page read");
        wr('h808, 2, 32'h0000_E000, "R5 control low half");
        rdchk('h808, 4, "R5 upper half kept");
        rdchk('h80A, 2, "R5 upper half read");

        // R11: control reached via page 2 aperture
        wr('h808, 4, 32'h0000_4000, "R11 select page 2");
        wr('hC08, 4, 32'h7700_4055, "R11 write via aperture");
        rdchk('h808, 4, "R11 direct view");
        rdchk('hC08, 4, "R11 aperture view");
        access(1'b0, 'h808, 4, 32'h0, rd, er);
        chk(rd == 32'h7700_4055, "R11 literal value", rd, 32'h7700_4055);

        // R1: reset clears the control register again
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        mctrl = '0;
        access(1'b0, 'h808, 4, 32'h0, rd, er);
        chk(rd == 32'h0 && !er, "R1 control after second reset", rd, 32'h0);

        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule